// File: doc/BRIEF.md
# Reset Pulse Sequencer with Cause Classification

This block runs the chip-level reset sequence on an open-drain reset pad. On any internal reset request it pulls the pad low for a fixed drive interval and then lets go. After a further fixed settle interval it looks at the pad level through a synchronizer. It combines that level with two pending-cause flags, oscillator-monitor failure and watchdog expiry, and picks which reset vector class the core should fetch. The internal reset output covers the whole sequence. If something outside keeps the pad low past the sequence, the internal reset stays asserted until the pad is seen high again.

The pad is never driven high. The block only has a pull-low enable and reads the observed pad level on a separate input. The vector-select code is a register. It changes only at the sample point, so the core sees a steady value once internal reset drops. The drive length, the settle length and the synchronizer depth are parameters, checked at elaboration.

Top module: `rstseq_top`

## Requirements
- R1: After a request, `pad_pull_low` is high for exactly `DRIVE_CYC` clock cycles and then low. The block only ever pulls the pad low, and the pull is high only while `sys_rst` is high.
- R2: `sys_rst` stays high for the first `DRIVE_CYC + SETTLE_CYC` cycles after a request.
- R3: The pad level passes through `SYNC_STAGES` flops before use. If the synchronized pad is low at the sample point, `sys_rst` stays high until the synchronized pad is high. It then falls `SYNC_STAGES + 1` cycles after the pad rises.
- R4: If the pad is sampled low, `vec_sel` becomes 2'b00 (common power-on vector), whatever the flags are.
- R5: If the pad is sampled high and `osc_fail_pend` is high, `vec_sel` becomes 2'b01 (clock-monitor vector), whatever `wdog_pend` is.
- R6: If the pad is sampled high, `osc_fail_pend` is low and `wdog_pend` is high, `vec_sel` becomes 2'b10 (watchdog vector).
- R7: If the pad is sampled high and neither flag is pending, `vec_sel` becomes 2'b00.
- R8: `vec_sel` changes only at the sample point. While `sys_rst` is low, changes on the flags or the pad leave `vec_sel`, `sys_rst` and `pad_pull_low` unchanged.
- R9: A request that arrives during an active sequence restarts the full drive interval from the cycle after the request.
- R10: While `rst_n` is low, `sys_rst` = 1, `pad_pull_low` = 1 and `vec_sel` = 2'b00. A complete sequence follows the release of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low; it starts a sequence |
| seq_req | input | 1 | Internal reset request, one or more cycles |
| pad_level | input | 1 | Observed level of the reset pad |
| osc_fail_pend | input | 1 | Oscillator-monitor failure pending |
| wdog_pend | input | 1 | Watchdog expiry pending |
| pad_pull_low | output | 1 | Pull-low enable for the open-drain pad |
| sys_rst | output | 1 | Internal reset, active high |
| vec_sel | output | 2 | Vector class: 00 common, 01 clock monitor, 10 watchdog |

## Verification
The bench builds the block with `DRIVE_CYC` = 8, `SETTLE_CYC` = 4 and `SYNC_STAGES` = 2. With these values each sequence lasts only twelve cycles, so the bench can follow every cycle of the pull and settle phases. It sweeps all eight combinations of the two flags and of an outside hold on the pad. The short intervals also make it cheap to restart a sequence partway through and to time the late release after the pad rises, edge by edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRIVE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_HOLD  = 2'd3
   } seq_state_e;

   localparam logic [1:0] VEC_COMMON = 2'b00;
   localparam logic [1:0] VEC_CLKMON = 2'b01;
   localparam logic [1:0] VEC_WDOG   = 2'b10;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg <= STAGES'({stg, d});
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/rstseq_classify.sv
module rstseq_classify
   import rstseq_pkg::*;
(
   input  logic       osc_fail,
   input  logic       wdog,
   output logic [1:0] vec
);

   always_comb begin
      if (osc_fail)  vec = VEC_CLKMON;
      else if (wdog) vec = VEC_WDOG;
      else           vec = VEC_COMMON;
   end

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int DRIVE_CYC   = 512,
   parameter int SETTLE_CYC  = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       seq_req,
   input  logic       pad_level,
   input  logic       osc_fail_pend,
   input  logic       wdog_pend,
   output logic       pad_pull_low,
   output logic       sys_rst,
   output logic [1:0] vec_sel
);

   localparam int MAX_CYC = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_CYC - 1);
   localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

   generate
      if (DRIVE_CYC < 2) begin : g_bad_drive
         $error("DRIVE_CYC must be at least 2");
      end
      if (SETTLE_CYC <= SYNC_STAGES) begin : g_bad_settle
         $error("SETTLE_CYC must exceed SYNC_STAGES");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt;
   logic             cnt_clr, cnt_en, smp;
   logic             pad_sync;
   logic [1:0]       cls_vec;
   logic [1:0]       vec_q;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_level),
      .q     (pad_sync)
   );

   rstseq_timer #(.W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .en    (cnt_en),
      .cnt   (cnt)
   );

   rstseq_classify u_cls (
      .osc_fail (osc_fail_pend),
      .wdog     (wdog_pend),
      .vec      (cls_vec)
   );

   assign cnt_en = (state_q == ST_DRIVE) || (state_q == ST_WAIT);

   always_comb begin
      state_d = state_q;
      cnt_clr = 1'b0;
      smp     = 1'b0;
      case (state_q)
         ST_DRIVE: if (cnt == DRIVE_LAST) begin
            state_d = ST_WAIT;
            cnt_clr = 1'b1;
         end
         ST_WAIT: if (cnt == SETTLE_LAST) begin
            smp     = 1'b1;
            state_d = pad_sync ? ST_IDLE : ST_HOLD;
         end
         ST_HOLD: if (pad_sync) state_d = ST_IDLE;
         default: ;
      endcase
      if (seq_req) begin
         state_d = ST_DRIVE;
         cnt_clr = 1'b1;
         smp     = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_DRIVE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vec_q <= VEC_COMMON;
      else if (smp) vec_q <= pad_sync ? cls_vec : VEC_COMMON;
   end

   assign pad_pull_low = (state_q == ST_DRIVE);
   assign sys_rst      = (state_q != ST_IDLE);
   assign vec_sel      = vec_q;

   // R1
   pull_within_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_pull_low |-> sys_rst);

   // R2
   drive_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DRIVE) |-> (cnt <= DRIVE_LAST));

   // R3
   release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst) |-> $past(pad_sync));

   // R4
   low_common_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && !pad_sync) |=> (vec_sel == VEC_COMMON) && sys_rst);

   // R5
   clkmon_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && pad_sync && osc_fail_pend) |=> (vec_sel == VEC_CLKMON));

   // R8
   vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_rst && $past(!sys_rst)) |-> $stable(vec_sel));

   // R8
   vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_sel != 2'b11);

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_req |=> (pad_pull_low && cnt == '0));

endmodule

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;

   localparam int D = 8;
   localparam int W = 4;
   localparam int S = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic seq_req = 1'b0;
   logic ext_low = 1'b0;
   logic osc = 1'b0;
   logic wd = 1'b0;
   logic pull, srst;
   logic [1:0] vsel;
   logic pad;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   assign pad = !(pull || ext_low);

   rstseq_top #(.DRIVE_CYC(D), .SETTLE_CYC(W), .SYNC_STAGES(S)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .seq_req       (seq_req),
      .pad_level     (pad),
      .osc_fail_pend (osc),
      .wdog_pend     (wd),
      .pad_pull_low  (pull),
      .sys_rst       (srst),
      .vec_sel       (vsel)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic request();
      seq_req = 1'b1;
      step();
      seq_req = 1'b0;
   endtask

   // Called at the negedge just after the edge that entered the drive phase.
   task automatic run_body(input bit ext_long, input int expv);
      for (int i = 0; i < D + W; i++) begin
         check("R1 pull", int'(pull), (i < D) ? 1 : 0);
         check("R2 sys_rst", int'(srst), 1);
         step();
      end
      if (!ext_long) begin
         check("R2 release", int'(srst), 0);
         check("R5/R6/R7 vec", int'(vsel), expv);
      end else begin
         for (int i = 0; i < 5; i++) begin
            check("R3 held", int'(srst), 1);
            check("R1 no pull", int'(pull), 0);
            step();
         end
         ext_low = 1'b0;
         for (int i = 0; i < S; i++) begin
            step();
            check("R3 sync delay", int'(srst), 1);
         end
         step();
         check("R3 late release", int'(srst), 0);
         check("R4 low common", int'(vsel), 0);
      end
   endtask

   task automatic idle_probe(input int expv);
      for (int i = 0; i < 3; i++) begin
         osc = ~osc;
         wd = ~wd;
         ext_low = (i != 1);
         step();
         check("R8 vec hold", int'(vsel), expv);
         check("R8 no rst", int'(srst), 0);
         check("R8 no pull", int'(pull), 0);
      end
      ext_low = 1'b0;
      step();
   endtask

   initial begin
      @(negedge clk);
      // R10 reset state
      check("R10 sys_rst", int'(srst), 1);
      check("R10 pull", int'(pull), 1);
      check("R10 vec", int'(vsel), 0);
      rst_n = 1'b1;
      run_body(1'b0, 0);

      for (int c = 0; c < 8; c++) begin
         automatic bit e = c[2];
         automatic int expv;
         osc = c[0];
         wd = c[1];
         ext_low = e;
         expv = e ? 0 : (c[0] ? 1 : (c[1] ? 2 : 0));
         request();
         run_body(e, expv);
         idle_probe(expv);
      end

      // R9 restart partway through the drive phase
      osc = 1'b0;
      wd = 1'b1;
      request();
      for (int i = 0; i < 5; i++) step();
      request();
      run_body(1'b0, 2);
      // R9 restart during the settle phase
      osc = 1'b1;
      request();
      for (int i = 0; i < D + 2; i++) step();
      check("R9 in settle", int'(pull), 0);
      request();
      run_body(1'b0, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule